// File: doc/BRIEF.md
# Latched Bidirectional Parity Transceiver

This block sits between two symmetric 9-bit buses, A and B. Each bus carries 8 data bits and one parity bit. Each bus feeds its own level-sensitive capture latch. The contents of one latch are sent out on the opposite bus. The outgoing parity bit is either recomputed from the 8 latched data bits or copied unchanged from the latched parity bit. A single mode input selects this for both directions at once. An odd/even sense input sets the parity rule for generation and for checking.

The parity of both latches is checked all the time. The result appears on one active-low error output per bus, and checking continues while neither bus is driven. The error output of the receiving bus (the bus being driven) is suppressed while that side's latch is holding. The tri-state pads are modelled as separate data-in, data-out and drive-enable signals. The drive enables come from two active-low output-enable inputs. Asserting both enables at once is illegal: the block drives neither bus and raises a conflict flag.

The design targets FPGAs. Each latch is a clocked register with a transparent bypass multiplexer. All outputs are registered, so every output reflects the inputs of the previous clock edge.

Top module: `dual_latch_parity_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both latches to all zeros and sets the outputs as follows: `a_drive`, `b_drive` and `oe_conflict` = 0, both error outputs = 1, all data-out and parity-out bits = 0.
- R2: While a side's latch enable is 1, its latch follows that side's data-in and parity-in. While the enable is 0, the latch holds the value it took at the last clock edge where the enable was 1. The opposite bus's data output shows the latch data one clock after the edge.
- R3: With `fwd_sel` = 0 (generate), each outgoing parity bit is computed from the 8 data bits of the source latch: XOR of the bits when `odd_sel` = 0, inverted XOR when `odd_sel` = 1. A holding latch therefore gives parity of the held data.
- R4: With `fwd_sel` = 1 (feed-through), each outgoing parity bit equals the parity bit held in the source latch.
- R5: An error is flagged when the 9 latched bits of a side contain an odd number of ones (`odd_sel` = 0) or an even number (`odd_sel` = 1). The error outputs are active low (0 = error) and registered.
- R6: Both error outputs keep checking their own latches while `a_oe_n` and `b_oe_n` are both 1.
- R7: With `a_oe_n` = 0 and `b_oe_n` = 1, `a_drive` goes to 1 and `b_drive` to 0 one clock later, and bus A carries the B latch contents. The case with the roles of A and B swapped behaves the same way.
- R8: With `a_oe_n` = 0 and `b_oe_n` = 0, both drive outputs are 0 and `oe_conflict` is 1 one clock later. `oe_conflict` is 0 in every other case.
- R9: The error output of the driven (receiving) side is held at 1 while that side's latch enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_din | input | 8 | Bus A data pad input |
| a_pin | input | 1 | Bus A parity pad input |
| a_le | input | 1 | Bus A latch enable, 1 = transparent |
| a_oe_n | input | 1 | Active-low enable to drive bus A |
| b_din | input | 8 | Bus B data pad input |
| b_pin | input | 1 | Bus B parity pad input |
| b_le | input | 1 | Bus B latch enable, 1 = transparent |
| b_oe_n | input | 1 | Active-low enable to drive bus B |
| fwd_sel | input | 1 | 0 = generate parity, 1 = feed parity through |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| a_dout | output | 8 | Data driven onto bus A (from B latch) |
| a_pout | output | 1 | Parity driven onto bus A |
| a_drive | output | 1 | Pad enable for bus A |
| b_dout | output | 8 | Data driven onto bus B (from A latch) |
| b_pout | output | 1 | Parity driven onto bus B |
| b_drive | output | 1 | Pad enable for bus B |
| a_err_n | output | 1 | Active-low parity error, A latch |
| b_err_n | output | 1 | Active-low parity error, B latch |
| oe_conflict | output | 1 | Both enables asserted at once |

## Verification
The bench builds the block with its default data width of 8. At that width the bus values with extreme and alternating bit patterns (0x00, 0xFF, 0xA5) can be driven directly, together with matching and mismatching parity bits. A directed sweep covers all 64 combinations of the two output enables, the two latch enables, the mode select and the parity sense, each with several data patterns. A long pseudo-random run follows, in which latches repeatedly capture and hold while the direction and modes change underneath them.

// File: rtl/pxcvr_pkg.sv
package pxcvr_pkg;
  localparam int NUM_SIDES = 2;
  localparam int SIDE_A    = 0;
  localparam int SIDE_B    = 1;
  localparam int DEF_DATA_W = 8;
endpackage

// File: rtl/pxcvr_latch.sv
// Register with transparent bypass: q follows d while le is high,
// otherwise the stored value.
module pxcvr_latch #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  assign q = le ? d : held;

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else     held <= q;
  end
endmodule

// File: rtl/pxcvr_parity.sv
// Parity generator and checker for one latch.
module pxcvr_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par_in,
  input  logic              odd,
  output logic              gen_par,
  output logic              err
);
  logic data_x;

  assign data_x  = ^data;
  assign gen_par = data_x ^ odd;
  assign err     = data_x ^ par_in ^ odd;
endmodule

// File: rtl/pxcvr_side.sv
// One bus side: capture latch plus its parity logic.
module pxcvr_side #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              le,
  input  logic              odd,
  input  logic [DATA_W-1:0] din,
  input  logic              pin,
  output logic [DATA_W-1:0] lat_data,
  output logic              lat_par,
  output logic              gen_par,
  output logic              err
);
  localparam int LW = DATA_W + 1;

  logic [LW-1:0] lat_q;

  pxcvr_latch #(.W(LW)) u_latch (
    .clk (clk),
    .rst (rst),
    .le  (le),
    .d   ({din, pin}),
    .q   (lat_q)
  );

  assign lat_data = lat_q[LW-1:1];
  assign lat_par  = lat_q[0];

  pxcvr_parity #(.DATA_W(DATA_W)) u_par (
    .data    (lat_data),
    .par_in  (lat_par),
    .odd     (odd),
    .gen_par (gen_par),
    .err     (err)
  );
endmodule

// File: rtl/dual_latch_parity_xcvr.sv
module dual_latch_parity_xcvr
  import pxcvr_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_din,
  input  logic              a_pin,
  input  logic              a_le,
  input  logic              a_oe_n,
  input  logic [DATA_W-1:0] b_din,
  input  logic              b_pin,
  input  logic              b_le,
  input  logic              b_oe_n,
  input  logic              fwd_sel,
  input  logic              odd_sel,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_pout,
  output logic              a_drive,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_pout,
  output logic              b_drive,
  output logic              a_err_n,
  output logic              b_err_n,
  output logic              oe_conflict
);
  logic [NUM_SIDES-1:0][DATA_W-1:0] din_v, lat_data_v, dout_v;
  logic [NUM_SIDES-1:0]             pin_v, le_v, lat_par_v, gen_par_v;
  logic [NUM_SIDES-1:0]             err_v, pout_v, drive_v, err_n_v;
  logic [NUM_SIDES-1:0]             drive_nx;
  logic                             conflict_nx;

  assign din_v[SIDE_A] = a_din;
  assign din_v[SIDE_B] = b_din;
  assign pin_v[SIDE_A] = a_pin;
  assign pin_v[SIDE_B] = b_pin;
  assign le_v[SIDE_A]  = a_le;
  assign le_v[SIDE_B]  = b_le;

  // A bus is driven only when its own enable alone is active.
  assign drive_nx[SIDE_A] = ~a_oe_n & b_oe_n;
  assign drive_nx[SIDE_B] = ~b_oe_n & a_oe_n;
  assign conflict_nx      = ~a_oe_n & ~b_oe_n;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam int SRC = NUM_SIDES - 1 - s;

    logic out_par_nx;
    logic err_nx;

    pxcvr_side #(.DATA_W(DATA_W)) u_side (
      .clk      (clk),
      .rst      (rst),
      .le       (le_v[s]),
      .odd      (odd_sel),
      .din      (din_v[s]),
      .pin      (pin_v[s]),
      .lat_data (lat_data_v[s]),
      .lat_par  (lat_par_v[s]),
      .gen_par  (gen_par_v[s]),
      .err      (err_v[s])
    );

    assign out_par_nx = fwd_sel ? lat_par_v[SRC] : gen_par_v[SRC];
    // Receiving side reports nothing while its latch holds.
    assign err_nx     = err_v[s] & ~(drive_nx[s] & ~le_v[s]);

    always_ff @(posedge clk) begin
      if (rst) begin
        dout_v[s]  <= '0;
        pout_v[s]  <= 1'b0;
        drive_v[s] <= 1'b0;
        err_n_v[s] <= 1'b1;
      end else begin
        dout_v[s]  <= lat_data_v[SRC];
        pout_v[s]  <= out_par_nx;
        drive_v[s] <= drive_nx[s];
        err_n_v[s] <= ~err_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe_conflict <= 1'b0;
    else     oe_conflict <= conflict_nx;
  end

  assign a_dout  = dout_v[SIDE_A];
  assign b_dout  = dout_v[SIDE_B];
  assign a_pout  = pout_v[SIDE_A];
  assign b_pout  = pout_v[SIDE_B];
  assign a_drive = drive_v[SIDE_A];
  assign b_drive = drive_v[SIDE_B];
  assign a_err_n = err_n_v[SIDE_A];
  assign b_err_n = err_n_v[SIDE_B];
endmodule

// File: rtl/pxcvr_checker.sv
module pxcvr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              a_pin,
  input logic              a_le,
  input logic              a_oe_n,
  input logic              b_pin,
  input logic              b_le,
  input logic              b_oe_n,
  input logic              fwd_sel,
  input logic              odd_sel,
  input logic [DATA_W-1:0] a_dout,
  input logic              a_pout,
  input logic              a_drive,
  input logic [DATA_W-1:0] b_dout,
  input logic              b_pout,
  input logic              b_drive,
  input logic              a_err_n,
  input logic              b_err_n,
  input logic              oe_conflict
);
  assert_conflict_R8: assert property (@(posedge clk) disable iff (rst)
    (!a_oe_n && !b_oe_n) |=> (oe_conflict && !a_drive && !b_drive));

  assert_one_driver_R7: assert property (@(posedge clk) disable iff (rst)
    !(a_drive && b_drive));

  assert_rx_err_quiet_a_R9: assert property (@(posedge clk) disable iff (rst)
    (!a_oe_n && b_oe_n && !a_le) |=> a_err_n);

  assert_rx_err_quiet_b_R9: assert property (@(posedge clk) disable iff (rst)
    (!b_oe_n && a_oe_n && !b_le) |=> b_err_n);

  assert_feed_through_R4: assert property (@(posedge clk) disable iff (rst)
    (fwd_sel && b_le) |=> (a_pout == $past(b_pin)));

  assert_gen_parity_R3: assert property (@(posedge clk) disable iff (rst)
    !fwd_sel |=> (b_pout == ((^b_dout) ^ $past(odd_sel))));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !a_le |=> $stable(b_dout));
endmodule

bind dual_latch_parity_xcvr pxcvr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .a_pin       (a_pin),
  .a_le        (a_le),
  .a_oe_n      (a_oe_n),
  .b_pin       (b_pin),
  .b_le        (b_le),
  .b_oe_n      (b_oe_n),
  .fwd_sel     (fwd_sel),
  .odd_sel     (odd_sel),
  .a_dout      (a_dout),
  .a_pout      (a_pout),
  .a_drive     (a_drive),
  .b_dout      (b_dout),
  .b_pout      (b_pout),
  .b_drive     (b_drive),
  .a_err_n     (a_err_n),
  .b_err_n     (b_err_n),
  .oe_conflict (oe_conflict)
);

// File: tb/dual_latch_parity_xcvr_tb.sv
`timescale 1ns/1ps
module dual_latch_parity_xcvr_tb;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] a_din = '0, b_din = '0;
  logic a_pin = 0, a_le = 0, a_oe_n = 1, b_pin = 0, b_le = 0, b_oe_n = 1;
  logic fwd_sel = 0, odd_sel = 0;
  logic [DW-1:0] a_dout, b_dout;
  logic a_pout, a_drive, b_pout, b_drive, a_err_n, b_err_n, oe_conflict;

  always #5 clk = ~clk;

  dual_latch_parity_xcvr #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .a_din(a_din), .a_pin(a_pin), .a_le(a_le), .a_oe_n(a_oe_n),
    .b_din(b_din), .b_pin(b_pin), .b_le(b_le), .b_oe_n(b_oe_n),
    .fwd_sel(fwd_sel), .odd_sel(odd_sel),
    .a_dout(a_dout), .a_pout(a_pout), .a_drive(a_drive),
    .b_dout(b_dout), .b_pout(b_pout), .b_drive(b_drive),
    .a_err_n(a_err_n), .b_err_n(b_err_n), .oe_conflict(oe_conflict)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit have_exp = 0;

  // reference model state
  logic [DW:0] mq_a = '0, mq_b = '0;
  logic [DW-1:0] e_adout, e_bdout;
  logic e_apout, e_bpout, e_adrive, e_bdrive, e_aerrn, e_berrn, e_conf;
  string t_rst, t_par, t_aerr, t_berr;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    chk({t_rst, "R2 a_dout"}, int'(a_dout), int'(e_adout));
    chk({t_rst, "R2 b_dout"}, int'(b_dout), int'(e_bdout));
    chk({t_rst, t_par, " a_pout"}, int'(a_pout), int'(e_apout));
    chk({t_rst, t_par, " b_pout"}, int'(b_pout), int'(e_bpout));
    chk({t_rst, "R7 a_drive"}, int'(a_drive), int'(e_adrive));
    chk({t_rst, "R7 b_drive"}, int'(b_drive), int'(e_bdrive));
    chk({t_rst, "R8 oe_conflict"}, int'(oe_conflict), int'(e_conf));
    chk({t_rst, t_aerr, " a_err_n"}, int'(a_err_n), int'(e_aerrn));
    chk({t_rst, t_berr, " b_err_n"}, int'(b_err_n), int'(e_berrn));
  endtask

  task automatic step(input logic r, input logic [DW-1:0] ad, input logic ap,
                      input logic ale, input logic aoe, input logic [DW-1:0] bd,
                      input logic bp, input logic ble, input logic boe,
                      input logic fs, input logic os);
    logic [DW:0] la, lb;
    logic ea, eb;
    @(negedge clk);
    if (have_exp && !done) compare();
    rst = r; a_din = ad; a_pin = ap; a_le = ale; a_oe_n = aoe;
    b_din = bd; b_pin = bp; b_le = ble; b_oe_n = boe; fwd_sel = fs; odd_sel = os;
    if (r) begin
      mq_a = '0; mq_b = '0;
      e_adout = '0; e_bdout = '0; e_apout = 0; e_bpout = 0;
      e_adrive = 0; e_bdrive = 0; e_conf = 0; e_aerrn = 1; e_berrn = 1;
      t_rst = "R1 "; t_par = "R1"; t_aerr = "R1"; t_berr = "R1";
    end else begin
      la = ale ? {ad, ap} : mq_a;
      lb = ble ? {bd, bp} : mq_b;
      mq_a = la; mq_b = lb;
      e_adrive = !aoe && boe;
      e_bdrive = !boe && aoe;
      e_conf   = !aoe && !boe;
      e_adout  = lb[DW:1];
      e_bdout  = la[DW:1];
      e_apout  = fs ? lb[0] : (($countones(lb[DW:1]) % 2 == 1) ^ os);
      e_bpout  = fs ? la[0] : (($countones(la[DW:1]) % 2 == 1) ^ os);
      ea = (($countones(la) % 2) == 1) ^ os;
      eb = (($countones(lb) % 2) == 1) ^ os;
      t_aerr = (aoe && boe) ? "R6" : "R5";
      t_berr = t_aerr;
      if (e_adrive && !ale) begin ea = 0; t_aerr = "R9"; end
      if (e_bdrive && !ble) begin eb = 0; t_berr = "R9"; end
      e_aerrn = !ea; e_berrn = !eb;
      t_rst = ""; t_par = fs ? "R4" : "R3";
    end
    have_exp = 1;
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] nxt(input logic [31:0] v);
    logic [31:0] x;
    x = v ^ (v << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    logic [DW-1:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h01;
    // R1: reset phase
    step(1, 8'h3C, 1, 1, 0, 8'hC3, 1, 1, 1, 0, 0);
    step(1, 8'h3C, 1, 1, 0, 8'hC3, 1, 1, 1, 0, 0);
    // R1: cleared latches observed through held outputs
    step(0, 8'h77, 1, 0, 1, 8'h55, 1, 0, 1, 1, 0);
    step(0, 8'h77, 1, 0, 0, 8'h55, 1, 0, 1, 1, 1);
    // directed sweep over all enable/mode combinations
    for (int c = 0; c < 64; c++) begin
      for (int p = 0; p < 4; p++) begin
        step(0, pats[p], p[0], c[3], c[0], ~pats[3-p], p[1],
             c[4], c[1], c[2], c[5]);
      end
    end
    // R8 conflict then release
    step(0, 8'h12, 0, 1, 0, 8'h34, 1, 1, 0, 0, 0);
    step(0, 8'h12, 0, 1, 1, 8'h34, 1, 1, 0, 0, 0);
    // pseudo-random run
    for (int i = 0; i < 3000; i++) begin
      lfsr = nxt(lfsr);
      step(0, lfsr[7:0], lfsr[8], lfsr[9], lfsr[10], lfsr[18:11], lfsr[19],
           lfsr[20], lfsr[21], lfsr[22], lfsr[23]);
    end
    // mid-run reset returns to R1 state
    step(1, 8'hFF, 1, 1, 0, 8'hFF, 0, 1, 1, 1, 1);
    step(0, 8'hFF, 1, 0, 1, 8'hFF, 0, 0, 1, 0, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule